// File: doc/BRIEF.md
# Soak-Test Thermal and Over-Current Trip Monitor

This block watches a device under a long thermal soak. Once per second a sample strobe presents three signed temperature readings and one unsigned supply-current reading. When any temperature is above its limit, the block raises a shutdown request on that sample. It also raises the request when the supply current stays more than 20 % above a captured idle level for longer than a set number of consecutive samples. The request is held until a clear command arrives. A cause code records which condition tripped first.

The idle current level is taken from the current input only when the capture command is given. Until that happens, current supervision is off. Each sample also produces a one-cycle log strobe, so a downstream recorder can store the sample together with the current trip state. Temperatures are two's-complement values in tenths of a degree, so the default limit of 85.0 °C is the value 850.

Top module: `soak_trip_monitor`

## Requirements
- R1: After reset, `shutdown_req` is 0, `trip_cause` is 0 and `log_stb` is 0.
- R2: `log_stb` is high for exactly one cycle, one clock after each cycle in which `sample_vld` is high. It is never high otherwise. `shutdown_req` and `trip_cause` show the result of that sample in the same cycle as `log_stb`.
- R3: On a sample where a temperature channel is strictly greater than `TEMP_LIMIT` (signed compare, default 850), the block latches a shutdown. A reading equal to the limit, or a negative reading, does not trip.
- R4: Cause codes are: 0 none, 1 channel 0, 2 channel 1, 3 channel 2, 4 over-current. When several conditions hold on one sample, temperature wins over current, and the lowest-numbered hot channel wins among temperatures.
- R5: Once latched, `shutdown_req` stays 1 and `trip_cause` keeps its first value until `trip_clr`. Later trip conditions do not change the cause.
- R6: `trip_clr` sets `shutdown_req` and `trip_cause` to 0 on the next clock. If a trip condition arrives in the same cycle as `trip_clr`, the clear wins.
- R7: Before the first baseline capture, the current input never causes a trip.
- R8: A sample is over-current when 5·cur > 6·baseline. An over-current trip happens on the (`PERSIST_SAMPLES`+1)-th consecutive over-current sample (default: the 11th).
- R9: A sample with 5·cur ≤ 6·baseline is not over-current, because exactly 20 % above does not count. Such a sample restarts the consecutive count.
- R10: `baseline_cap` loads the baseline from `cur` and restarts the consecutive count. The baseline changes at no other time.
- R11: Input values in cycles without `sample_vld` have no effect on `shutdown_req` or `trip_cause`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sample_vld | input | 1 | One-cycle strobe marking a 1 Hz sample |
| temp0 | input | TEMP_W | Heat-slug temperature, signed, 0.1 °C units |
| temp1 | input | TEMP_W | Board temperature near the power stage, signed, 0.1 °C units |
| temp2 | input | TEMP_W | Ambient temperature, signed, 0.1 °C units |
| cur | input | CUR_W | Supply current, unsigned |
| baseline_cap | input | 1 | Load idle baseline from `cur` |
| trip_clr | input | 1 | Clear the latched shutdown and cause |
| shutdown_req | output | 1 | Latched shutdown request |
| trip_cause | output | 3 | Latched cause code (see R4) |
| log_stb | output | 1 | One-cycle strobe per processed sample |

## Verification
A corrupt persistence counter shows at the ports as a shutdown that comes one or more samples early or late. A scan of exactly eleven over-current samples, a break, and eleven more exposes it on the first wrong sample. A bad latch or priority path shows as a wrong cause code on the log strobe of the very sample that tripped, or as a cause that changes on a later strobe. A baseline loaded at the wrong time moves the trip threshold, and a current exactly 20 % above the baseline separates a correct threshold from a shifted one on the next log strobe.

// File: rtl/smon_pkg.sv
package smon_pkg;

  localparam int unsigned NUM_TEMP = 3;
  localparam int unsigned CAUSE_W  = 3;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_T0   = 3'd1,
    CAUSE_T1   = 3'd2,
    CAUSE_T2   = 3'd3,
    CAUSE_OCUR = 3'd4
  } trip_cause_e;

endpackage

// File: rtl/smon_temp_cmp.sv
module smon_temp_cmp #(
  parameter int unsigned TEMP_W     = 12,
  parameter int unsigned NUM_CH     = 3,
  parameter int          TEMP_LIMIT = 850,
  localparam int unsigned IDX_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic signed [TEMP_W-1:0] temp_i [NUM_CH],
  output logic                     hot_o,
  output logic [IDX_W-1:0]         hot_idx_o
);

  logic [NUM_CH-1:0] over;

  // one comparator per channel
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign over[g] = (temp_i[g] > TEMP_LIMIT);
  end

  // lowest-numbered hot channel wins: scan downward so the last hit is lowest
  always_comb begin
    hot_idx_o = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (over[i]) hot_idx_o = IDX_W'(i);
    end
    hot_o = |over;
  end

endmodule

// File: rtl/smon_ocur.sv
module smon_ocur #(
  parameter int unsigned CUR_W           = 16,
  parameter int unsigned PERSIST_SAMPLES = 10,
  localparam int unsigned PROD_W         = CUR_W + 3,
  localparam int unsigned CNT_W          = $clog2(PERSIST_SAMPLES + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_vld_i,
  input  logic             cap_i,
  input  logic [CUR_W-1:0] cur_i,
  output logic             oc_trip_o
);

  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(PERSIST_SAMPLES);

  logic [CUR_W-1:0]  base_q, base_d;
  logic              bvalid_q, bvalid_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [PROD_W-1:0] cur_x5, base_x6;
  logic              over;

  // exact 1.2x threshold: 5*cur > 6*base, built from shifts and adds
  always_comb begin
    cur_x5  = (PROD_W'(cur_i) << 2) + PROD_W'(cur_i);
    base_x6 = (PROD_W'(base_q) << 2) + (PROD_W'(base_q) << 1);
    over    = bvalid_q && (cur_x5 > base_x6);
  end

  // next state
  always_comb begin
    base_d   = base_q;
    bvalid_d = bvalid_q;
    cnt_d    = cnt_q;
    if (cap_i) begin
      base_d   = cur_i;
      bvalid_d = 1'b1;
      cnt_d    = '0;
    end else if (sample_vld_i) begin
      if (over) begin
        if (cnt_q != CNT_SAT) cnt_d = cnt_q + 1'b1;
      end else begin
        cnt_d = '0;
      end
    end
  end

  assign oc_trip_o = sample_vld_i && !cap_i && over && (cnt_q == CNT_SAT);

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      bvalid_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      base_q   <= base_d;
      bvalid_q <= bvalid_d;
      cnt_q    <= cnt_d;
    end
  end

endmodule

// File: rtl/smon_trip_latch.sv
module smon_trip_latch #(
  parameter int unsigned IDX_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sample_vld_i,
  input  logic                     clr_i,
  input  logic                     hot_i,
  input  logic [IDX_W-1:0]         hot_idx_i,
  input  logic                     oc_trip_i,
  output logic                     sd_o,
  output smon_pkg::trip_cause_e    cause_o,
  output logic                     log_o
);

  import smon_pkg::*;

  logic        sd_q, sd_d;
  trip_cause_e cause_q, cause_d;
  logic        log_q, log_d;

  always_comb begin
    sd_d    = sd_q;
    cause_d = cause_q;
    log_d   = sample_vld_i;
    if (clr_i) begin
      sd_d    = 1'b0;
      cause_d = CAUSE_NONE;
    end else if (!sd_q && sample_vld_i) begin
      if (hot_i) begin
        sd_d    = 1'b1;
        cause_d = trip_cause_e'(CAUSE_W'(hot_idx_i) + CAUSE_W'(1));
      end else if (oc_trip_i) begin
        sd_d    = 1'b1;
        cause_d = CAUSE_OCUR;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_q    <= 1'b0;
      cause_q <= CAUSE_NONE;
      log_q   <= 1'b0;
    end else begin
      sd_q    <= sd_d;
      cause_q <= cause_d;
      log_q   <= log_d;
    end
  end

  assign sd_o    = sd_q;
  assign cause_o = cause_q;
  assign log_o   = log_q;

endmodule

// File: rtl/soak_trip_monitor.sv
module soak_trip_monitor #(
  parameter int unsigned TEMP_W          = 12,
  parameter int unsigned CUR_W           = 16,
  parameter int          TEMP_LIMIT      = 850,
  parameter int unsigned PERSIST_SAMPLES = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sample_vld,
  input  logic signed [TEMP_W-1:0] temp0,
  input  logic signed [TEMP_W-1:0] temp1,
  input  logic signed [TEMP_W-1:0] temp2,
  input  logic [CUR_W-1:0]         cur,
  input  logic                     baseline_cap,
  input  logic                     trip_clr,
  output logic                     shutdown_req,
  output logic [2:0]               trip_cause,
  output logic                     log_stb
);

  import smon_pkg::*;

  localparam int unsigned IDX_W = $clog2(NUM_TEMP);

  logic signed [TEMP_W-1:0] temps [NUM_TEMP];
  logic                     hot;
  logic [IDX_W-1:0]         hot_idx;
  logic                     oc_trip;
  trip_cause_e              cause;

  assign temps[0] = temp0;
  assign temps[1] = temp1;
  assign temps[2] = temp2;

  smon_temp_cmp #(
    .TEMP_W    (TEMP_W),
    .NUM_CH    (NUM_TEMP),
    .TEMP_LIMIT(TEMP_LIMIT)
  ) u_tcmp (
    .temp_i   (temps),
    .hot_o    (hot),
    .hot_idx_o(hot_idx)
  );

  smon_ocur #(
    .CUR_W          (CUR_W),
    .PERSIST_SAMPLES(PERSIST_SAMPLES)
  ) u_ocur (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_vld_i(sample_vld),
    .cap_i       (baseline_cap),
    .cur_i       (cur),
    .oc_trip_o   (oc_trip)
  );

  smon_trip_latch #(
    .IDX_W(IDX_W)
  ) u_latch (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_vld_i(sample_vld),
    .clr_i       (trip_clr),
    .hot_i       (hot),
    .hot_idx_i   (hot_idx),
    .oc_trip_i   (oc_trip),
    .sd_o        (shutdown_req),
    .cause_o     (cause),
    .log_o       (log_stb)
  );

  assign trip_cause = cause;

endmodule

// File: rtl/smon_chk.sv
module smon_chk #(
  parameter int unsigned TEMP_W     = 12,
  parameter int unsigned CUR_W      = 16,
  parameter int          TEMP_LIMIT = 850
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     sample_vld,
  input logic signed [TEMP_W-1:0] temp0,
  input logic signed [TEMP_W-1:0] temp1,
  input logic signed [TEMP_W-1:0] temp2,
  input logic [CUR_W-1:0]         cur,
  input logic                     baseline_cap,
  input logic                     trip_clr,
  input logic                     shutdown_req,
  input logic [2:0]               trip_cause,
  input logic                     log_stb
);

  logic seen_cap;
  logic temps_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_cap <= 1'b0;
    else if (baseline_cap) seen_cap <= 1'b1;
  end

  assign temps_ok = (temp0 <= TEMP_LIMIT) && (temp1 <= TEMP_LIMIT) && (temp2 <= TEMP_LIMIT);

  a_r2_log_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |=> log_stb);

  a_r2_no_stray_log: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld |=> !log_stb);

  a_r3_ch0_trips: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && !trip_clr && !shutdown_req && temp0 > TEMP_LIMIT)
      |=> (shutdown_req && trip_cause == 3'd1));

  a_r4_ch1_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && !trip_clr && !shutdown_req && temp0 <= TEMP_LIMIT && temp1 > TEMP_LIMIT)
      |=> (shutdown_req && trip_cause == 3'd2));

  a_r5_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown_req && !trip_clr) |=> (shutdown_req && $stable(trip_cause)));

  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    trip_clr |=> (!shutdown_req && trip_cause == 3'd0));

  a_r7_no_current_before_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && !seen_cap && !baseline_cap && temps_ok && !shutdown_req) |=> !shutdown_req);

  a_r11_quiet_between_samples: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_vld && !shutdown_req) |=> !shutdown_req);

endmodule

bind soak_trip_monitor smon_chk #(
  .TEMP_W    (TEMP_W),
  .CUR_W     (CUR_W),
  .TEMP_LIMIT(TEMP_LIMIT)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .sample_vld  (sample_vld),
  .temp0       (temp0),
  .temp1       (temp1),
  .temp2       (temp2),
  .cur         (cur),
  .baseline_cap(baseline_cap),
  .trip_clr    (trip_clr),
  .shutdown_req(shutdown_req),
  .trip_cause  (trip_cause),
  .log_stb     (log_stb)
);

// File: tb/soak_trip_monitor_tb_top.sv
`timescale 1ns/1ps
module soak_trip_monitor_tb_top;

  localparam int TEMP_W  = 12;
  localparam int CUR_W   = 16;
  localparam int LIMIT   = 850;
  localparam int PERSIST = 10;

  logic                     clk = 1'b0;
  logic                     rst_n;
  logic                     sample_vld;
  logic signed [TEMP_W-1:0] temp0, temp1, temp2;
  logic [CUR_W-1:0]         cur;
  logic                     baseline_cap;
  logic                     trip_clr;
  logic                     shutdown_req;
  logic [2:0]               trip_cause;
  logic                     log_stb;

  always #2.5 clk = ~clk;

  soak_trip_monitor #(
    .TEMP_W(TEMP_W), .CUR_W(CUR_W), .TEMP_LIMIT(LIMIT), .PERSIST_SAMPLES(PERSIST)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld),
    .temp0(temp0), .temp1(temp1), .temp2(temp2), .cur(cur),
    .baseline_cap(baseline_cap), .trip_clr(trip_clr),
    .shutdown_req(shutdown_req), .trip_cause(trip_cause), .log_stb(log_stb)
  );

  int errors = 0;
  int checks = 0;

  // expected items: {sd, cause} plus requirement tag
  logic [3:0] exp_q [$];
  string      tag_q [$];

  // reference state computed from the requirements
  int m_sd = 0, m_cause = 0, m_bvalid = 0, m_base = 0, m_cnt = 0;

  task automatic check(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic do_sample(input string req, input int t0, input int t1, input int t2,
                           input int c, input bit clr);
    int hot_cause;
    bit over, oc;
    @(negedge clk);
    temp0 = TEMP_W'(t0); temp1 = TEMP_W'(t1); temp2 = TEMP_W'(t2);
    cur = CUR_W'(c); trip_clr = clr; sample_vld = 1'b1;
    hot_cause = 0;
    if (t2 > LIMIT) hot_cause = 3;
    if (t1 > LIMIT) hot_cause = 2;
    if (t0 > LIMIT) hot_cause = 1;
    over = (m_bvalid != 0) && (5 * c > 6 * m_base);
    oc = over && (m_cnt >= PERSIST);
    if (m_bvalid != 0) m_cnt = over ? ((m_cnt < PERSIST) ? m_cnt + 1 : m_cnt) : 0;
    if (clr) begin
      m_sd = 0; m_cause = 0;
    end else if (m_sd == 0) begin
      if (hot_cause != 0) begin m_sd = 1; m_cause = hot_cause; end
      else if (oc) begin m_sd = 1; m_cause = 4; end
    end
    exp_q.push_back({m_sd[0], m_cause[2:0]});
    tag_q.push_back(req);
    @(negedge clk);
    sample_vld = 1'b0; trip_clr = 1'b0;
  endtask

  task automatic capture(input int c);
    @(negedge clk);
    cur = CUR_W'(c); baseline_cap = 1'b1;
    @(negedge clk);
    baseline_cap = 1'b0;
    m_base = c; m_bvalid = 1; m_cnt = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    trip_clr = 1'b1;
    @(negedge clk);
    trip_clr = 1'b0;
    m_sd = 0; m_cause = 0;
    check("R6 clr sd", int'(shutdown_req), 0);
    check("R6 clr cause", int'(trip_cause), 0);
  endtask

  task automatic run_n(input string req, input int n, input int c);
    for (int i = 0; i < n; i++) do_sample(req, 250, 300, 220, c, 1'b0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && log_stb) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected log_stb", 1, 0);
      end else begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " sd"}, int'(shutdown_req), int'(e[3]));
        check({t, " cause"}, int'(trip_cause), int'(e[2:0]));
      end
    end
  end

  bit done = 0;

  initial begin
    #(5ns * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sample_vld = 1'b0; baseline_cap = 1'b0; trip_clr = 1'b0;
    temp0 = '0; temp1 = '0; temp2 = '0; cur = '0;
    repeat (3) @(negedge clk);
    check("R1 reset sd", int'(shutdown_req), 0);
    check("R1 reset cause", int'(trip_cause), 0);
    check("R1 reset log", int'(log_stb), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_n("R2 nominal", 3, 1000);
    run_n("R7 no baseline", 15, 60000);

    do_sample("R3 at limit", 250, 850, 220, 500, 1'b0);
    do_sample("R3 above limit", 250, 851, 220, 500, 1'b0);
    do_sample("R5 cause held", 900, 300, 220, 500, 1'b0);
    pulse_clr();

    do_sample("R4 all hot", 900, 900, 900, 500, 1'b0);
    pulse_clr();
    do_sample("R3 negative", -400, -2048, -1, 500, 1'b0);

    // R11: hot inputs without sample strobe
    @(negedge clk);
    temp0 = TEMP_W'(2000);
    repeat (5) @(negedge clk);
    check("R11 ignored sd", int'(shutdown_req), 0);
    check("R11 ignored log", int'(log_stb), 0);

    capture(1000);
    run_n("R9 exactly 20pct", 15, 1200);
    run_n("R8 over", 10, 1201);
    run_n("R9 restart", 1, 1000);
    run_n("R8 over again", 11, 1201);
    pulse_clr();

    do_sample("R4 temp beats current", 250, 300, 900, 1300, 1'b0);
    pulse_clr();

    run_n("R10 pre", 1, 1000);
    run_n("R10 partial", 5, 1500);
    capture(1000);
    run_n("R10 after capture", 11, 1500);
    pulse_clr();

    do_sample("R6 clear beats trip", 900, 300, 220, 500, 1'b1);
    do_sample("R3 retrip", 900, 300, 220, 500, 1'b0);

    repeat (4) @(negedge clk);
    check("R2 queue drained", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule